// File: doc/BRIEF.md
# Trigger-pending event buffer

This block sits between several serial-readout ingest ports and one shared drain port. A first-level accept pulse claims a fixed-size event slot. Each ingest port then writes its own section of that event at its own pace. The slot is held until a second-level decision names the event. A reject returns the slot at once and emits nothing. An accept streams the event out, one word per cycle, port 0 first and the last port at the end. Every port section is preceded by a header word that holds the port number, the byte count and a truncation flag. The slot is returned once the last word has gone out.

Slots are claimed and returned in strict arrival order, because decisions arrive in the same order as the events they name. The source is warned by a busy flag while it still has one slot of margin. A port section larger than the slot's share for that port is cut to fit, and the cut is reported in that section's header. The default parameters give eight ports, sixteen slots and 16 bytes per port section. A production build sets the section size to 2048.

Top module: `event_hold_buffer`

## Requirements
- R1: After reset, `next_evt` is 0 and `busy`, `dec_ready` and `out_valid` are all 0.
- R2: An `evt_start` pulse claims a slot and advances `next_evt` by one, as long as fewer than NSLOT events are held. When all NSLOT slots are held, the pulse is ignored and `next_evt` stays unchanged.
- R3: `busy` is high exactly while fewer than 2 slots are free, that is, while NSLOT-1 or more events are held.
- R4: A byte with `in_valid` high goes to the oldest event that the port has not yet closed. `in_last` closes that section, and the byte in the same cycle is included when `in_valid` is also high. A port with no open event discards its bytes and its `in_last`.
- R5: `dec_ready` is high only when all of the following hold: no drain is running, at least one event is held, and every port has closed its section of the oldest held event.
- R6: A decision whose `dec_evt` differs from the number of the oldest held event is ignored. It produces no output and frees nothing.
- R7: A matching reject frees the oldest slot and produces no output words.
- R8: A matching accept streams the sections of ports 0 through NPORT-1 in order, one word per cycle with no gaps. Each section is a header followed by its bytes. `out_last` marks the final word, and the slot is freed after it.
- R9: In a header (`out_hdr`=1), the top bit `out_data[8]` is the truncation flag, `out_data[7:5]` is the port number and `out_data[4:0]` is the byte count (default widths). In a data word, the byte sits in `out_data[7:0]` and the top bit is 0.
- R10: Bytes beyond SEC_BYTES in one port section are dropped. The count then reads SEC_BYTES and the truncation flag is set. A section of exactly SEC_BYTES bytes is not flagged.
- R11: Slots are reused in ring order. Events still read back correctly after the claim counter has passed NSLOT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_start | input | 1 | First-level accept pulse; claims a slot |
| next_evt | output | EVW | Number that the next claimed event will get |
| busy | output | 1 | Fewer than two slots free |
| in_valid | input | NPORT | Per-port byte strobe |
| in_data | input | 8*NPORT | Per-port byte, port p in bits [8p+7:8p] |
| in_last | input | NPORT | Per-port section close |
| dec_valid | input | 1 | Decision strobe |
| dec_accept | input | 1 | 1 = accept, 0 = reject |
| dec_evt | input | EVW | Event number the decision refers to |
| dec_ready | output | 1 | A decision can be taken this cycle |
| out_valid | output | 1 | Output word valid |
| out_hdr | output | 1 | Output word is a section header |
| out_last | output | 1 | Final word of the event |
| out_data | output | 1+PW+CW | Header or data word |

## Verification
The assertions assume three things about the inputs. A decision is only offered while `dec_ready` is high. Each port closes its sections in the order the events were claimed. The drain port never needs to stall, because the block has no output backpressure. The bench waits for `dec_ready` before every decision and writes whole events one at a time, with all ports active together. It also sends stray bytes to a port with no open event, a decision that names the wrong event, and a start pulse while all slots are held. These stay within what the design accepts while still touching every discard path.

// File: rtl/event_hold_buffer.sv
module event_hold_buffer #(
  parameter int NPORT     = 8,
  parameter int NSLOT     = 16,
  parameter int SEC_BYTES = 16,
  parameter int EVW       = 8,
  localparam int PW  = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int SW  = $clog2(NSLOT),
  localparam int BW  = $clog2(SEC_BYTES),
  localparam int CW  = $clog2(SEC_BYTES + 1),
  localparam int ODW = 1 + PW + CW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_start,
  output logic [EVW-1:0]     next_evt,
  output logic               busy,
  input  logic [NPORT-1:0]   in_valid,
  input  logic [NPORT*8-1:0] in_data,
  input  logic [NPORT-1:0]   in_last,
  input  logic               dec_valid,
  input  logic               dec_accept,
  input  logic [EVW-1:0]     dec_evt,
  output logic               dec_ready,
  output logic               out_valid,
  output logic               out_hdr,
  output logic               out_last,
  output logic [ODW-1:0]     out_data
);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA} drain_t;

  logic [EVW-1:0] alloc_cnt, head_cnt;
  logic [EVW-1:0] pend;
  logic           full;
  logic [SW-1:0]  head_slot;
  drain_t         state;
  logic [PW-1:0]  rp;
  logic [CW-1:0]  ri;
  logic           dec_take;

  logic [NPORT-1:0] pdone;
  logic [7:0]       rd_byte [NPORT];
  logic [CW-1:0]    rd_len  [NPORT];
  logic             rd_ovf  [NPORT];

  assign pend      = alloc_cnt - head_cnt;
  assign full      = (pend == EVW'(NSLOT));
  assign busy      = (pend >= EVW'(NSLOT - 1));
  assign next_evt  = alloc_cnt;
  assign head_slot = head_cnt[SW-1:0];
  assign dec_ready = (state == S_IDLE) && (pend != '0) && (&pdone);
  assign dec_take  = dec_valid && dec_ready && (dec_evt == head_cnt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 alloc_cnt <= '0;
    else if (evt_start && !full) alloc_cnt <= alloc_cnt + 1'b1;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic [EVW-1:0] pcnt;
    logic [CW-1:0]  wcnt;
    logic           wovf;
    logic [7:0]     mem  [NSLOT*SEC_BYTES];
    logic [CW-1:0]  lenq [NSLOT];
    logic           ovfq [NSLOT];
    logic           seg_open, room;
    logic [SW-1:0]  wslot;

    assign seg_open = (pcnt != alloc_cnt);
    assign room     = (wcnt < CW'(SEC_BYTES));
    assign wslot    = pcnt[SW-1:0];
    assign pdone[g] = (pcnt != head_cnt);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pcnt <= '0;
        wcnt <= '0;
        wovf <= 1'b0;
      end else if (seg_open) begin
        if (in_last[g]) begin
          pcnt <= pcnt + 1'b1;
          wcnt <= '0;
          wovf <= 1'b0;
        end else if (in_valid[g]) begin
          if (room) wcnt <= wcnt + 1'b1;
          else      wovf <= 1'b1;
        end
      end

    always_ff @(posedge clk) begin
      if (seg_open && in_valid[g] && room)
        mem[{wslot, wcnt[BW-1:0]}] <= in_data[g*8 +: 8];
      if (seg_open && in_last[g]) begin
        lenq[wslot] <= wcnt + CW'(in_valid[g] && room);
        ovfq[wslot] <= wovf | (in_valid[g] & ~room);
      end
    end

    assign rd_byte[g] = mem[{head_slot, ri[BW-1:0]}];
    assign rd_len[g]  = lenq[head_slot];
    assign rd_ovf[g]  = ovfq[head_slot];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_IDLE;
      head_cnt  <= '0;
      rp        <= '0;
      ri        <= '0;
      out_valid <= 1'b0;
      out_hdr   <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_hdr   <= 1'b0;
      out_last  <= 1'b0;
      case (state)
        S_IDLE:
          if (dec_take) begin
            if (dec_accept) begin
              state <= S_HDR;
              rp    <= '0;
            end else begin
              head_cnt <= head_cnt + 1'b1;
            end
          end
        S_HDR: begin
          out_valid <= 1'b1;
          out_hdr   <= 1'b1;
          out_data  <= {rd_ovf[rp], rp, rd_len[rp]};
          ri        <= '0;
          if (rd_len[rp] != '0) begin
            state <= S_DATA;
          end else if (rp == PW'(NPORT - 1)) begin
            out_last <= 1'b1;
            state    <= S_IDLE;
            head_cnt <= head_cnt + 1'b1;
          end else begin
            rp <= rp + 1'b1;
          end
        end
        S_DATA: begin
          out_valid <= 1'b1;
          out_data  <= ODW'(rd_byte[rp]);
          ri        <= ri + 1'b1;
          if (ri == rd_len[rp] - CW'(1)) begin
            if (rp == PW'(NPORT - 1)) begin
              out_last <= 1'b1;
              state    <= S_IDLE;
              head_cnt <= head_cnt + 1'b1;
            end else begin
              rp    <= rp + 1'b1;
              state <= S_HDR;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end

endmodule

// File: rtl/event_hold_buffer_chk.sv
module event_hold_buffer_chk #(
  parameter int EVW       = 8,
  parameter int CW        = 5,
  parameter int ODW       = 9,
  parameter int SEC_BYTES = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           evt_start,
  input logic [EVW-1:0] next_evt,
  input logic           busy,
  input logic           full,
  input logic           dec_valid,
  input logic           dec_ready,
  input logic           out_valid,
  input logic           out_hdr,
  input logic           out_last,
  input logic [ODW-1:0] out_data
);

  assert_hold_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && evt_start) |=> $stable(next_evt));

  assert_claim_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_start |=> $stable(next_evt));

  assert_busy_rise_on_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(evt_start));

  assert_busy_fall_on_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(dec_valid && dec_ready) || out_last));

  assert_no_ready_mid_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !dec_ready);

  assert_last_is_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_gap_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  assert_burst_opens_hdr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(out_valid)) |-> out_hdr);

  assert_flag_needs_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hdr && (out_data[CW-1:0] != CW'(SEC_BYTES))) |-> !out_data[ODW-1]);

endmodule

bind event_hold_buffer event_hold_buffer_chk #(
  .EVW(EVW), .CW(CW), .ODW(ODW), .SEC_BYTES(SEC_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .next_evt(next_evt),
  .busy(busy), .full(full), .dec_valid(dec_valid), .dec_ready(dec_ready),
  .out_valid(out_valid), .out_hdr(out_hdr), .out_last(out_last), .out_data(out_data)
);

// File: tb/event_hold_buffer_tb.sv
`timescale 1ns/1ps
module event_hold_buffer_tb;
  localparam int NPORT = 8, NSLOT = 16, SEC = 16, EVW = 8, CW = 5, PW = 3, ODW = 9;

  typedef struct {
    logic           hdr;
    logic           last;
    logic [ODW-1:0] data;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_start = 1'b0;
  logic [EVW-1:0] next_evt;
  logic busy;
  logic [NPORT-1:0] in_valid = '0, in_last = '0;
  logic [NPORT*8-1:0] in_data = '0;
  logic dec_valid = 1'b0, dec_accept = 1'b0;
  logic [EVW-1:0] dec_evt = '0;
  logic dec_ready, out_valid, out_hdr, out_last;
  logic [ODW-1:0] out_data;

  int vectors = 0, miscompares = 0;
  item_t expq[$];
  string cur_req = "R1";
  int len_tab [256][NPORT];

  always #2.5 clk = ~clk;

  event_hold_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .next_evt(next_evt), .busy(busy),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_evt(dec_evt), .dec_ready(dec_ready),
    .out_valid(out_valid), .out_hdr(out_hdr), .out_last(out_last), .out_data(out_data)
  );

  function automatic logic [7:0] gen(int e, int p, int i);
    return 8'(e * 37 + p * 11 + i * 5 + 1);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0d, expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      vectors++;
      if (expq.size() == 0) begin
        miscompares++;
        $display("FAIL %s unexpected output: got hdr=%0b last=%0b data=%h, expected no word",
                 cur_req, out_hdr, out_last, out_data);
      end else begin
        item_t e;
        e = expq.pop_front();
        if (e.hdr !== out_hdr || e.last !== out_last || e.data !== out_data) begin
          miscompares++;
          $display("FAIL %s stream: got hdr=%0b last=%0b data=%h, expected hdr=%0b last=%0b data=%h",
                   cur_req, out_hdr, out_last, out_data, e.hdr, e.last, e.data);
        end
      end
    end
  end

  task automatic start_evt();
    evt_start = 1'b1; tick(); evt_start = 1'b0;
  endtask

  task automatic fill(int e, input int lens[NPORT]);
    int mx = 1;
    for (int p = 0; p < NPORT; p++) begin
      len_tab[e & 255][p] = lens[p];
      if (lens[p] > mx) mx = lens[p];
    end
    for (int c = 0; c < mx; c++) begin
      for (int p = 0; p < NPORT; p++) begin
        in_valid[p] = (c < lens[p]);
        in_data[p*8 +: 8] = gen(e, p, c);
        in_last[p] = (lens[p] == 0) ? (c == 0) : (c == lens[p] - 1);
      end
      tick();
    end
    in_valid = '0; in_last = '0;
  endtask

  task automatic decide(int e, bit acc);
    while (!dec_ready) tick();
    if (acc) begin
      for (int p = 0; p < NPORT; p++) begin
        int n = len_tab[e & 255][p];
        int k = (n > SEC) ? SEC : n;
        item_t it;
        it.hdr = 1'b1; it.last = (p == NPORT - 1) && (k == 0);
        it.data = {(n > SEC), PW'(p), CW'(k)};
        expq.push_back(it);
        for (int i = 0; i < k; i++) begin
          it.hdr = 1'b0; it.last = (p == NPORT - 1) && (i == k - 1);
          it.data = ODW'(gen(e, p, i));
          expq.push_back(it);
        end
      end
    end
    dec_evt = EVW'(e); dec_accept = acc; dec_valid = 1'b1;
    tick();
    dec_valid = 1'b0;
  endtask

  task automatic drain_wait();
    for (int i = 0; i < 400 && expq.size() != 0; i++) tick();
    repeat (3) tick();
    check(expq.size() == 0, cur_req, "words still expected", expq.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int lens[NPORT];
    repeat (3) tick();
    check(next_evt == 0 && busy == 0 && dec_ready == 0 && out_valid == 0, "R1",
          "outputs in reset", {next_evt, busy, dec_ready, out_valid}, 0);
    rst_n = 1'b1;
    tick();
    check(next_evt == 0, "R1", "next_evt after reset", next_evt, 0);
    check(busy == 0 && dec_ready == 0, "R1", "busy/dec_ready after reset", {busy, dec_ready}, 0);

    // R4: stray bytes on port 3 with no open event are dropped
    cur_req = "R4";
    for (int c = 0; c < 3; c++) begin
      in_valid[3] = 1'b1; in_data[3*8 +: 8] = 8'hEE; in_last[3] = (c == 2);
      tick();
    end
    in_valid = '0; in_last = '0;
    check(dec_ready == 0, "R4", "no event created by stray bytes", dec_ready, 0);

    // event 0: mixed lengths, one over-long, one exactly full
    start_evt();
    check(next_evt == 1, "R2", "next_evt after claim", next_evt, 1);
    check(dec_ready == 0, "R5", "ready before ports close", dec_ready, 0);
    lens = '{3, 0, 20, 16, 1, 5, 2, 7};
    fill(0, lens);
    tick();
    check(dec_ready == 1, "R5", "ready once all ports closed", dec_ready, 1);

    // R6: wrong event number is ignored
    cur_req = "R6";
    dec_evt = 8'd5; dec_accept = 1'b1; dec_valid = 1'b1; tick(); dec_valid = 1'b0;
    repeat (4) tick();
    check(dec_ready == 1, "R6", "still pending after mismatch", dec_ready, 1);
    check(next_evt == 1, "R6", "next_evt untouched", next_evt, 1);

    cur_req = "R4 R8 R9 R10";
    decide(0, 1'b1);
    drain_wait();
    check(dec_ready == 0, "R8", "slot freed after drain", dec_ready, 0);

    // R7: reject
    cur_req = "R7";
    start_evt();
    lens = '{4, 4, 4, 4, 4, 4, 4, 4};
    fill(1, lens);
    decide(1, 1'b0);
    repeat (40) tick();
    check(dec_ready == 0 && busy == 0, "R7", "freed with no output", {dec_ready, busy}, 0);
    check(expq.size() == 0, "R7", "queue empty", expq.size(), 0);

    // R2/R3: fill every slot
    for (int k = 0; k < NSLOT; k++) begin
      start_evt();
      check(busy == (k + 1 >= NSLOT - 1), "R3", "busy vs held count", busy, (k + 1 >= NSLOT - 1));
    end
    check(next_evt == 18, "R2", "next_evt when full", next_evt, 18);
    start_evt();
    check(next_evt == 18, "R2", "claim ignored when full", next_evt, 18);

    // R11: data through ring wrap, alternating decisions
    cur_req = "R10 R11";
    for (int e = 2; e < 18; e++) begin
      for (int p = 0; p < NPORT; p++) lens[p] = (e * 3 + p * 5) % 21;
      fill(e, lens);
    end
    for (int e = 2; e < 18; e++) decide(e, (e % 2) == 0);
    drain_wait();
    check(busy == 0 && dec_ready == 0, "R11", "all freed after wrap", {busy, dec_ready}, 0);

    start_evt();
    check(next_evt == 19, "R11", "claim counter past NSLOT", next_evt, 19);
    lens = '{9, 16, 17, 0, 0, 2, 11, 1};
    fill(18, lens);
    decide(18, 1'b1);
    drain_wait();

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule